// File: doc/BRIEF.md
# Two-Address I2C Command and Data Slave

This block is an I2C target that listens on two fixed 7-bit addresses. Bytes written to the command address are commands. Bytes exchanged through the data address are payload, and they move in both directions. Every byte the controller writes to a matching address is acknowledged on the bus. It is then handed to the surrounding logic as a one-cycle strobe with its byte value and a flag that tells a command from data.

When the controller reads through the data address, the block pulls one byte per transfer slot from a byte source. The source keeps its next byte presented. A one-cycle take strobe tells the source that the byte has been consumed. The read continues for as long as the controller acknowledges, and the block lets go of SDA as soon as the controller withholds the acknowledge.

SCL and SDA are sampled by a system clock that runs at least eight times faster than SCL, and SDA is driven only as an open-drain pull-down. A separate request input is registered and drives an active-low interrupt line that tells the controller the device needs service.

Top module: `i2c_dual_addr_slave`

## Requirements
- R1: The command address is 7'b0011011 and the data address is 7'b0011010. A write to either one, and a read from the data address, is acknowledged by pulling SDA low in the ninth clock of the address byte.
- R2: A read request to the command address (address byte 8'h37) is not acknowledged. It produces no take strobe and no received byte.
- R3: An address byte that matches neither address is not acknowledged. The block then forwards nothing and never drives SDA until the next START or STOP.
- R4: After the command address with R/W=0, any number of bytes may follow. Each is acknowledged and presented with rx_is_cmd=1.
- R5: After the data address with R/W=0, each byte is acknowledged and presented with rx_is_cmd=0.
- R6: After the data address with R/W=1, each byte is taken from tx_byte with a one-cycle tx_take pulse and shifted out MSB first. A controller ACK (SDA low) leads to the next byte. A controller NACK (SDA high) makes the block release SDA and take no further byte.
- R7: A repeated START ends the current transfer and begins a new address phase, with no STOP in between.
- R8: A STOP returns the block to idle with SDA released.
- R9: The block changes its SDA drive only while SCL is low.
- R10: int_n is low exactly when irq_req was high at the previous system clock edge.
- R11: During reset, sda_oe=0, rx_valid=0, tx_take=0 and int_n=1.
- R12: rx_valid is a single-cycle pulse per received byte. The byte is assembled MSB first, and a receive strobe never coincides with a take strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_is_cmd | output | 1 | 1 for a command byte, 0 for a data byte |
| rx_byte | output | 8 | Received byte value |
| tx_byte | input | 8 | Next byte to send on a read |
| tx_take | output | 1 | One-cycle strobe: tx_byte was consumed |
| irq_req | input | 1 | Internal service request |
| int_n | output | 1 | Active-low interrupt to the controller |

## Verification
A wrong state in the byte engine shows up within one SCL period. The symptom can be a missing or extra acknowledge bit, a forwarded byte carrying the wrong command flag, or a take strobe after the controller's NACK. A stale address decision surfaces at the next repeated START, when the following byte is routed wrongly. An early or late SDA drive is visible on the same SCL low phase. The interrupt line is compared against the request on every system clock, so a lag of one cycle is caught at once.

// File: rtl/i2c_dual_addr_slave.sv
module i2c_dual_addr_slave #(
  parameter logic [6:0] CMD_ADDR  = 7'b0011011,
  parameter logic [6:0] DATA_ADDR = 7'b0011010,
  parameter int         SYNC_LEN  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic       rx_valid,
  output logic       rx_is_cmd,
  output logic [7:0] rx_byte,
  input  logic [7:0] tx_byte,
  output logic       tx_take,
  input  logic       irq_req,
  output logic       int_n
);

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_WR, S_ACKW, S_ACK, S_RD, S_RDACK, S_RDNXT
  } st_t;

  logic [SYNC_LEN-1:0] scl_sync, sda_sync;
  logic       scl_d, sda_d;
  st_t        st;
  logic [2:0] bitcnt;
  logic [7:0] shreg;
  logic       is_cmd, is_read;

  wire scl_s     = scl_sync[SYNC_LEN-1];
  wire sda_s     = sda_sync[SYNC_LEN-1];
  wire scl_rise  = scl_s & ~scl_d;
  wire scl_fall  = ~scl_s & scl_d;
  wire start_det = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  wire [7:0] in_byte = {shreg[6:0], sda_s};
  wire hit_cmd   = (in_byte[7:1] == CMD_ADDR) & ~in_byte[0];
  wire hit_data  = (in_byte[7:1] == DATA_ADDR);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
      int_n    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_LEN-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_LEN-2:0], sda_i};
      scl_d    <= scl_s;
      sda_d    <= sda_s;
      int_n    <= ~irq_req;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st        <= S_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      is_cmd    <= 1'b0;
      is_read   <= 1'b0;
      sda_oe    <= 1'b0;
      rx_valid  <= 1'b0;
      rx_is_cmd <= 1'b0;
      rx_byte   <= '0;
      tx_take   <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      tx_take  <= 1'b0;
      if (start_det) begin
        st     <= S_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          S_IDLE: ;
          S_ADDR, S_WR:
            if (scl_rise) begin
              shreg  <= in_byte;
              bitcnt <= bitcnt + 3'd1;
              if (bitcnt == 3'd7) begin
                if (st == S_ADDR) begin
                  is_cmd  <= hit_cmd;
                  is_read <= in_byte[0];
                  st      <= (hit_cmd | hit_data) ? S_ACKW : S_IDLE;
                end else begin
                  rx_valid  <= 1'b1;
                  rx_byte   <= in_byte;
                  rx_is_cmd <= is_cmd;
                  st        <= S_ACKW;
                end
              end
            end
          S_ACKW:
            if (scl_fall) begin
              sda_oe <= 1'b1;
              st     <= S_ACK;
            end
          S_ACK, S_RDNXT:
            if (scl_fall) begin
              bitcnt <= '0;
              if (is_read) begin
                shreg   <= tx_byte;
                tx_take <= 1'b1;
                sda_oe  <= ~tx_byte[7];
                st      <= S_RD;
              end else begin
                sda_oe <= 1'b0;
                st     <= S_WR;
              end
            end
          S_RD:
            if (scl_fall) begin
              if (bitcnt == 3'd7) begin
                sda_oe <= 1'b0;
                st     <= S_RDACK;
              end else begin
                bitcnt <= bitcnt + 3'd1;
                shreg  <= {shreg[6:0], 1'b0};
                sda_oe <= ~shreg[6];
              end
            end
          S_RDACK:
            if (scl_rise) st <= sda_s ? S_IDLE : S_RDNXT;
          default: st <= S_IDLE;
        endcase
      end
    end

  a_r9_drive_on_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) && !$past(start_det || stop_det) |-> !scl_d);

  a_r12_rx_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r12_rx_tx_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && tx_take));

  a_r6_take_in_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |-> !scl_d);

  a_r2_no_take_for_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |-> !is_cmd);

  a_r10_int_asserts: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |=> !int_n);

  a_r10_int_releases: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_req) |=> int_n);

endmodule

// File: tb/i2c_dual_addr_slave_tb.sv
module i2c_dual_addr_slave_tb;
  localparam int Q = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, irq_req = 1'b0;
  logic sda_oe, rx_valid, rx_is_cmd, tx_take, int_n;
  logic [7:0] rx_byte;
  wire  sda_bus = sda_m & ~sda_oe;

  logic [7:0] tx_src [4];
  int   tx_idx = 0;
  wire  [7:0] tx_byte = (tx_idx < 4) ? tx_src[tx_idx] : 8'hFF;

  int tests = 0, failed = 0, rx_rd = 0, r9_bad = 0, r10_bad = 0;
  bit done = 0;
  logic irq_q = 1'b0, oe_prev = 1'b0;
  logic [8:0] got [$];

  always #10 clk = ~clk;

  i2c_dual_addr_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .rx_valid(rx_valid), .rx_is_cmd(rx_is_cmd),
    .rx_byte(rx_byte), .tx_byte(tx_byte), .tx_take(tx_take),
    .irq_req(irq_req), .int_n(int_n)
  );

  always @(posedge clk) irq_q <= rst_n ? irq_req : 1'b0;

  always @(negedge clk) begin
    if (rx_valid) got.push_back({rx_is_cmd, rx_byte});
    if (tx_take) tx_idx <= tx_idx + 1;
    if (int_n !== ~irq_q) r10_bad++;
    if (rst_n && sda_oe !== oe_prev && scl_m) r9_bad++;
    oe_prev = sda_oe;
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic exp_rx(input string req, input bit cmd, input logic [7:0] b);
    if (rx_rd < got.size()) chk(req, int'(got[rx_rd]), int'({cmd, b}));
    else chk({req, " missing byte"}, 0, int'({cmd, b}));
    rx_rd++;
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_bit(input bit b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic read_bit(output bit b);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_bus; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic write_byte(input logic [7:0] b, output int ack);
    bit a;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    read_bit(a);
    ack = a ? 0 : 1;
  endtask

  task automatic read_byte(output logic [7:0] b, input bit mack);
    bit v;
    for (int i = 7; i >= 0; i--) begin read_bit(v); b[i] = v; end
    send_bit(~mack);
  endtask

  initial begin
    int ack;
    logic [7:0] rb;
    tx_src[0] = 8'h81; tx_src[1] = 8'h5A; tx_src[2] = 8'h7E; tx_src[3] = 8'h99;
    repeat (3) @(negedge clk);
    chk("R11 sda_oe", sda_oe, 0);
    chk("R11 rx_valid", rx_valid, 0);
    chk("R11 tx_take", tx_take, 0);
    chk("R11 int_n", int_n, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    i2c_start();
    write_byte(8'h36, ack); chk("R1 cmd address ack", ack, 1);
    write_byte(8'hA5, ack); chk("R4 cmd byte ack", ack, 1);
    write_byte(8'h00, ack); chk("R4 cmd byte ack", ack, 1);
    write_byte(8'hFF, ack); chk("R4 cmd byte ack", ack, 1);
    exp_rx("R4 cmd byte", 1'b1, 8'hA5);
    exp_rx("R4 cmd byte", 1'b1, 8'h00);
    exp_rx("R12 cmd byte msb first", 1'b1, 8'hFF);
    i2c_stop();
    chk("R8 released after stop", sda_oe, 0);

    i2c_start();
    write_byte(8'h34, ack); chk("R1 data write address ack", ack, 1);
    write_byte(8'h3C, ack); chk("R5 data byte ack", ack, 1);
    write_byte(8'hC3, ack); chk("R5 data byte ack", ack, 1);
    exp_rx("R5 data byte", 1'b0, 8'h3C);
    exp_rx("R5 data byte", 1'b0, 8'hC3);
    i2c_stop();

    i2c_start();
    write_byte(8'h35, ack); chk("R1 data read address ack", ack, 1);
    read_byte(rb, 1'b1); chk("R6 read byte 0", rb, 8'h81);
    read_byte(rb, 1'b1); chk("R6 read byte 1", rb, 8'h5A);
    read_byte(rb, 1'b0); chk("R6 read byte 2", rb, 8'h7E);
    wq();
    chk("R6 released after nack", sda_oe, 0);
    chk("R6 bytes taken", tx_idx, 3);
    i2c_stop();
    chk("R6 no take after nack", tx_idx, 3);

    i2c_start();
    write_byte(8'h37, ack); chk("R2 cmd read nack", ack, 0);
    i2c_stop();
    chk("R2 no take", tx_idx, 3);

    i2c_start();
    write_byte(8'h50, ack); chk("R3 foreign address nack", ack, 0);
    write_byte(8'h36, ack); chk("R3 ignored byte nack", ack, 0);
    i2c_start();
    write_byte(8'h36, ack); chk("R3 address after restart ack", ack, 1);
    write_byte(8'h44, ack); chk("R4 cmd byte ack", ack, 1);
    i2c_stop();
    exp_rx("R3 only post-restart byte", 1'b1, 8'h44);

    i2c_start();
    write_byte(8'h36, ack); chk("R7 cmd address ack", ack, 1);
    write_byte(8'h11, ack); chk("R7 cmd byte ack", ack, 1);
    i2c_start();
    write_byte(8'h34, ack); chk("R7 data address after restart", ack, 1);
    write_byte(8'h22, ack); chk("R7 data byte ack", ack, 1);
    i2c_start();
    write_byte(8'h35, ack); chk("R7 read address after restart", ack, 1);
    read_byte(rb, 1'b0); chk("R7 read after restart", rb, 8'h99);
    i2c_stop();
    exp_rx("R7 cmd before restart", 1'b1, 8'h11);
    exp_rx("R7 data after restart", 1'b0, 8'h22);

    @(negedge clk); irq_req = 1'b1;
    @(negedge clk); chk("R10 int low", int_n, 0);
    irq_req = 1'b0;
    @(negedge clk); chk("R10 int high", int_n, 1);

    chk("R12 no extra rx bytes", got.size(), rx_rd);
    chk("R9 sda changes with scl high", r9_bad, 0);
    chk("R10 per-cycle int mismatches", r10_bad, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end
endmodule